// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of programmable hardware triggers that a core uses for breakpoints and watchpoints. Each trigger has a control word and a compare value. Software reaches them through a narrow register port. An index register picks one trigger, and that trigger's control and compare words can then be read and written at their own port addresses.

On every cycle the core presents the access it is about to perform: its kind (instruction fetch, load or store), the current privilege level, the address and the data value. The block answers combinationally with a hit flag, the index of the trigger that fired and that trigger's action code. Each trigger qualifies the access by kind and by privilege level. It then compares either the address or the data value against its compare word, using one of six match modes. Triggers can be chained so that a run of them fires only as a group. The core decides what to do with a hit. All matching stops while the core reports that it is already in debug mode.

Top module: `trig_match_unit`

## Requirements
- R1: After reset the index register reads 0, every compare word reads 0 and every control word reads 0x2000_0000 (type field 2 in bits 31:28, all other fields 0), and no lookup hits.
- R2: A write to port address 0 loads the index register only when the written value is below NUM_TRIGGERS. Any other written value leaves the index unchanged.
- R3: Port address 1 reads and writes the selected control word and address 2 its compare word. In the control word, bits 19:0 and bit XLEN-5 (debug-only flag) are writable. Bits XLEN-1:XLEN-4 always read 2. Bits XLEN-6:XLEN-11 always read MASK_MAX. All other bits read 0. Address 3 reads 0.
- R4: Access kind codes are 0 fetch, 1 load, 2 store. Control bit 2 enables fetch, bit 0 enables loads and bit 1 enables stores. A trigger hits only for an enabled kind. Kind code 3 never hits.
- R5: Privilege codes are 0 user, 1 supervisor, 2 hypervisor, 3 machine. These are enabled by control bits 3, 4, 5 and 6 respectively. A trigger hits only at an enabled level.
- R6: A trigger whose control bits 2:0 are all zero never hits.
- R7: Control bit 19 picks the compared quantity: 0 the address, 1 the data value. Match mode (bits 10:7) code 0 hits on exact equality.
- R8: Mode 1 counts the trailing one bits of the compare word. It ignores that many low bits of both values and requires the rest to be equal.
- R9: Mode 2 hits when the value is not below the compare word. Mode 3 hits when the value is strictly below it. Both comparisons are unsigned.
- R10: In modes 4 and 5 the upper half of the compare word is a mask M. Mode 4 hits when (value & M) == (compare & M). Mode 5 hits when ((value >> XLEN/2) & M) == (compare & M).
- R11: Match modes 6 to 15 never hit.
- R12: A trigger with chain bit 11 set never fires alone. A run of consecutive chained triggers, ended by the next trigger whose chain bit is clear, fires only when every member matches. The hit is then reported for the ending trigger. A chained run with no ending trigger never fires.
- R13: When several triggers or groups fire, the lowest reported index wins. The hit action output carries bits 17:12 of that trigger's control word.
- R14: While the debug-cause input is nonzero no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_addr | input | 2 | Register port address: 0 index, 1 control, 2 compare |
| reg_wdata | input | XLEN | Register port write data |
| reg_rdata | output | XLEN | Register port read data, combinational |
| lk_kind | input | 2 | Access kind of the lookup |
| lk_priv | input | 2 | Privilege level of the lookup |
| lk_addr | input | XLEN | Access address |
| lk_data | input | XLEN | Access data value |
| dbg_cause | input | 3 | Nonzero while the core is in debug mode |
| hit | output | 1 | A trigger fired |
| hit_idx | output | IDX_W | Index of the firing trigger |
| hit_action | output | 6 | Action code of the firing trigger |

## Verification
The bench targets the boundaries of each compare mode:
- A NAPOT word with eight trailing ones must accept any low byte and reject the next block. A design that masks one bit too few or too many misses one side.
- Values just either side of 0x8000_0000 separate an unsigned compare from a signed one.
- For the half-word mask modes, the matching byte is placed in the wrong half. A design that swaps the two halves then reports a false hit.

For chains, the bench checks that a lone matching head stays silent and that a broken head silences its tail. It also checks that a chain with no ending trigger never fires. A resolver that ignores the chain bit would fire early on the head, or on a tail whose head failed.

Out-of-range index writes, unused triggers and the debug-cause gate are observed at the ports. A design that lets any of them through shows a changed readback or a spurious hit.

// File: rtl/trig_pkg.sv
package trig_pkg;
    // Stored, writable part of one trigger control word (bits 19:0 plus debug-only flag).
    typedef struct packed {
        logic       dmode;
        logic       sel_data;
        logic       timing;
        logic [5:0] action;
        logic       chain;
        logic [3:0] mode;
        logic [3:0] priv_en;  // [0] user .. [3] machine
        logic [2:0] acc_en;   // [0] load, [1] store, [2] fetch
    } trig_cfg_t;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_LOAD  = 2'd1;
    localparam logic [1:0] KIND_STORE = 2'd2;

    localparam logic [3:0] MODE_EQ    = 4'd0;
    localparam logic [3:0] MODE_NAPOT = 4'd1;
    localparam logic [3:0] MODE_GE    = 4'd2;
    localparam logic [3:0] MODE_LT    = 4'd3;
    localparam logic [3:0] MODE_MLO   = 4'd4;
    localparam logic [3:0] MODE_MHI   = 4'd5;

    localparam logic [3:0] TRIG_TYPE  = 4'd2;

    function automatic logic kind_enabled(trig_cfg_t c, logic [1:0] kind);
        case (kind)
            KIND_FETCH: return c.acc_en[2];
            KIND_LOAD:  return c.acc_en[0];
            KIND_STORE: return c.acc_en[1];
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/trig_regs.sv
module trig_regs
    import trig_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NUM_TRIGGERS = 4,
    parameter logic [5:0] MASK_MAX = 6'd0,
    localparam int IDX_W = (NUM_TRIGGERS > 1) ? $clog2(NUM_TRIGGERS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [1:0]                        addr,
    input  logic [XLEN-1:0]                   wdata,
    output logic [XLEN-1:0]                   rdata,
    output trig_cfg_t [NUM_TRIGGERS-1:0]      cfg_o,
    output logic [NUM_TRIGGERS-1:0][XLEN-1:0] cmp_o
);
    localparam logic [XLEN-1:0] COUNT_W = XLEN'(NUM_TRIGGERS);

    typedef struct packed {
        logic [IDX_W-1:0]                  sel;
        trig_cfg_t [NUM_TRIGGERS-1:0]      cfg;
        logic [NUM_TRIGGERS-1:0][XLEN-1:0] cmp;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                2'd0: if (wdata < COUNT_W) regs_d.sel = wdata[IDX_W-1:0];
                2'd1: regs_d.cfg[regs_q.sel] = {wdata[XLEN-5], wdata[19:0]};
                2'd2: regs_d.cmp[regs_q.sel] = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    trig_cfg_t cur_cfg;
    always_comb begin
        cur_cfg = regs_q.cfg[regs_q.sel];
        rdata = '0;
        case (addr)
            2'd0: rdata = XLEN'(regs_q.sel);
            2'd1: begin
                rdata[XLEN-1:XLEN-4]  = TRIG_TYPE;
                rdata[XLEN-5]         = cur_cfg.dmode;
                rdata[XLEN-6:XLEN-11] = MASK_MAX;
                rdata[19:0]           = cur_cfg[19:0];
            end
            2'd2: rdata = regs_q.cmp[regs_q.sel];
            default: rdata = '0;
        endcase
    end

    assign cfg_o = regs_q.cfg;
    assign cmp_o = regs_q.cmp;

    // R2: an out-of-range index write keeps the previous index
    assert_sel_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && wdata >= COUNT_W) |=> regs_q.sel == $past(regs_q.sel));
endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
    import trig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  trig_cfg_t       cfg,
    input  logic [XLEN-1:0] cmp,
    input  logic [1:0]      kind,
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] data,
    output logic            match
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] val, ign, hmask;
    logic            val_hit;

    always_comb begin
        val   = cfg.sel_data ? data : addr;
        ign   = cmp & ~(cmp + 1'b1);           // trailing-ones run of the compare word
        hmask = {{HALF{1'b0}}, cmp[XLEN-1:HALF]};
        case (cfg.mode)
            MODE_EQ:    val_hit = (val == cmp);
            MODE_NAPOT: val_hit = ((val & ~ign) == (cmp & ~ign));
            MODE_GE:    val_hit = (val >= cmp);
            MODE_LT:    val_hit = (val <  cmp);
            MODE_MLO:   val_hit = ((val & hmask) == (cmp & hmask));
            MODE_MHI:   val_hit = (((val >> HALF) & hmask) == (cmp & hmask));
            default:    val_hit = 1'b0;
        endcase
        match = val_hit && kind_enabled(cfg, kind) && cfg.priv_en[priv];
    end

    logic unused_cfg;
    assign unused_cfg = ^{cfg.dmode, cfg.timing, cfg.action, cfg.chain};
endmodule

// File: rtl/trig_chain_pick.sv
module trig_chain_pick #(
    parameter int NUM_TRIGGERS = 4,
    localparam int IDX_W = (NUM_TRIGGERS > 1) ? $clog2(NUM_TRIGGERS) : 1
) (
    input  logic [NUM_TRIGGERS-1:0]      matched,
    input  logic [NUM_TRIGGERS-1:0]      chained,
    input  logic [NUM_TRIGGERS-1:0][5:0] action,
    input  logic                         suppress,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx,
    output logic [5:0]                   hit_action
);
    logic [NUM_TRIGGERS-1:0] fire;
    logic                    run;

    always_comb begin
        run = 1'b1;
        for (int i = 0; i < NUM_TRIGGERS; i++) begin
            run     = run & matched[i];
            fire[i] = run & ~chained[i] & ~suppress;
            if (!chained[i]) run = 1'b1;
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NUM_TRIGGERS - 1; i >= 0; i--)
            if (fire[i]) hit_idx = IDX_W'(i);
        hit        = |fire;
        hit_action = hit ? action[hit_idx] : 6'd0;
    end
endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
    import trig_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NUM_TRIGGERS = 4,
    parameter logic [5:0] MASK_MAX = 6'd0,
    localparam int IDX_W = (NUM_TRIGGERS > 1) ? $clog2(NUM_TRIGGERS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [XLEN-1:0]  reg_wdata,
    output logic [XLEN-1:0]  reg_rdata,
    input  logic [1:0]       lk_kind,
    input  logic [1:0]       lk_priv,
    input  logic [XLEN-1:0]  lk_addr,
    input  logic [XLEN-1:0]  lk_data,
    input  logic [2:0]       dbg_cause,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [5:0]       hit_action
);
    trig_cfg_t [NUM_TRIGGERS-1:0]      cfg;
    logic [NUM_TRIGGERS-1:0][XLEN-1:0] cmp;
    logic [NUM_TRIGGERS-1:0]           matched, chained;
    logic [NUM_TRIGGERS-1:0][5:0]      action;

    trig_regs #(.XLEN(XLEN), .NUM_TRIGGERS(NUM_TRIGGERS), .MASK_MAX(MASK_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg_o(cfg), .cmp_o(cmp)
    );

    for (genvar g = 0; g < NUM_TRIGGERS; g++) begin : g_trig
        trig_cmp #(.XLEN(XLEN)) u_cmp (
            .cfg(cfg[g]), .cmp(cmp[g]), .kind(lk_kind), .priv(lk_priv),
            .addr(lk_addr), .data(lk_data), .match(matched[g])
        );
        assign chained[g] = cfg[g].chain;
        assign action[g]  = cfg[g].action;
    end

    trig_chain_pick #(.NUM_TRIGGERS(NUM_TRIGGERS)) u_pick (
        .matched(matched), .chained(chained), .action(action),
        .suppress(dbg_cause != 3'd0), .hit(hit), .hit_idx(hit_idx),
        .hit_action(hit_action)
    );

    assert_quiet_in_debug_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_cause != 3'd0) |-> !hit);
    assert_hit_ends_chain_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !cfg[hit_idx].chain);
    assert_hit_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> kind_enabled(cfg[hit_idx], lk_kind));
    assert_hit_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> cfg[hit_idx].priv_en[lk_priv]);
    assert_hit_action_R13: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hit_action == cfg[hit_idx].action);
endmodule

// File: tb/trig_match_unit_test.sv
module trig_match_unit_test;
    localparam int XLEN = 32;
    localparam int NT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [XLEN-1:0] reg_wdata = '0;
    logic [XLEN-1:0] reg_rdata;
    logic [1:0] lk_kind = 2'd0;
    logic [1:0] lk_priv = 2'd0;
    logic [XLEN-1:0] lk_addr = '0;
    logic [XLEN-1:0] lk_data = '0;
    logic [2:0] dbg_cause = 3'd0;
    logic hit;
    logic [1:0] hit_idx;
    logic [5:0] hit_action;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    trig_match_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_kind(lk_kind),
        .lk_priv(lk_priv), .lk_addr(lk_addr), .lk_data(lk_data),
        .dbg_cause(dbg_cause), .hit(hit), .hit_idx(hit_idx), .hit_action(hit_action)
    );

    localparam logic [2:0] A_FETCH = 3'b100, A_LOAD = 3'b001, A_STORE = 3'b010, A_ALL = 3'b111;
    localparam logic [3:0] P_M = 4'b1000, P_U = 4'b0001, P_ALL = 4'b1111;

    function automatic logic [31:0] mk(logic [3:0] mode, logic [5:0] act, logic ch,
                                       logic seld, logic [3:0] pv, logic [2:0] acc);
        return {12'd0, seld, 1'b0, act, ch, mode, pv, acc};
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic chk_rd(logic [1:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        n_run++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata actual %h expected %h", tag, reg_rdata, exp);
        end
    endtask

    task automatic prog(int idx, logic [31:0] c, logic [31:0] v);
        wr(2'd0, 32'(idx));
        wr(2'd1, c);
        wr(2'd2, v);
    endtask

    task automatic clear_all();
        for (int i = 0; i < NT; i++) prog(i, 32'd0, 32'd0);
    endtask

    task automatic look(logic [1:0] k, logic [1:0] p, logic [31:0] a, logic [31:0] d,
                        logic eh, logic [1:0] ei, logic [5:0] ea, string tag);
        lk_kind = k; lk_priv = p; lk_addr = a; lk_data = d;
        #1;
        n_run++;
        if (hit !== eh || (eh && (hit_idx !== ei || hit_action !== ea))) begin
            n_fail++;
            $display("FAIL %s: actual hit=%b idx=%0d act=%0d expected hit=%b idx=%0d act=%0d",
                     tag, hit, hit_idx, hit_action, eh, ei, ea);
        end
    endtask

    task automatic t_reset();
        chk_rd(2'd0, 32'd0, "R1 index");
        chk_rd(2'd1, 32'h2000_0000, "R1 control");
        chk_rd(2'd2, 32'd0, "R1 compare");
        look(2'd0, 2'd3, 32'd0, 32'd0, 1'b0, 2'd0, 6'd0, "R1 no hit");
    endtask

    task automatic t_select();
        wr(2'd0, 32'd2);
        chk_rd(2'd0, 32'd2, "R2 legal index");
        wr(2'd0, 32'd4);
        chk_rd(2'd0, 32'd2, "R2 index 4 ignored");
        wr(2'd0, 32'hFFFF_FFFF);
        chk_rd(2'd0, 32'd2, "R2 large index ignored");
    endtask

    task automatic t_regs();
        wr(2'd0, 32'd1);
        wr(2'd1, 32'hFFFF_FFFF);
        chk_rd(2'd1, 32'h280F_FFFF, "R3 control fields");
        wr(2'd2, 32'hCAFE_0123);
        chk_rd(2'd2, 32'hCAFE_0123, "R3 compare");
        chk_rd(2'd3, 32'd0, "R3 unused address");
        wr(2'd0, 32'd0);
        chk_rd(2'd2, 32'd0, "R3 other trigger untouched");
        clear_all();
    endtask

    task automatic t_qualify();
        prog(1, mk(4'd0, 6'd1, 1'b0, 1'b0, P_M, A_FETCH), 32'h100);
        look(2'd0, 2'd3, 32'h100, 0, 1'b1, 2'd1, 6'd1, "R4 fetch hit");
        look(2'd1, 2'd3, 32'h100, 0, 1'b0, 2'd0, 6'd0, "R4 load disabled");
        look(2'd2, 2'd3, 32'h100, 0, 1'b0, 2'd0, 6'd0, "R4 store disabled");
        look(2'd0, 2'd3, 32'h104, 0, 1'b0, 2'd0, 6'd0, "R7 address differs");
        prog(1, mk(4'd0, 6'd1, 1'b0, 1'b0, P_U, A_LOAD), 32'h100);
        look(2'd1, 2'd0, 32'h100, 0, 1'b1, 2'd1, 6'd1, "R5 user enabled");
        look(2'd1, 2'd3, 32'h100, 0, 1'b0, 2'd0, 6'd0, "R5 machine disabled");
        prog(1, mk(4'd0, 6'd1, 1'b0, 1'b0, P_ALL, A_ALL), 32'h100);
        look(2'd3, 2'd3, 32'h100, 0, 1'b0, 2'd0, 6'd0, "R4 kind 3 never hits");
        clear_all();
    endtask

    task automatic t_unused();
        prog(0, mk(4'd0, 6'd1, 1'b0, 1'b0, P_ALL, 3'b000), 32'd0);
        for (int k = 0; k < 3; k++)
            look(2'(k), 2'd3, 32'd0, 32'd0, 1'b0, 2'd0, 6'd0, "R6 unused trigger");
        clear_all();
    endtask

    task automatic t_modes();
        prog(2, mk(4'd0, 6'd1, 1'b0, 1'b1, P_ALL, A_LOAD), 32'hDEAD);
        look(2'd1, 2'd3, 32'hDEAD, 32'd0, 1'b0, 2'd0, 6'd0, "R7 data select ignores address");
        look(2'd1, 2'd3, 32'd0, 32'hDEAD, 1'b1, 2'd2, 6'd1, "R7 data equal");
        prog(2, mk(4'd1, 6'd1, 1'b0, 1'b0, P_ALL, A_LOAD), 32'h1000_00FF);
        look(2'd1, 2'd3, 32'h1000_0000, 0, 1'b1, 2'd2, 6'd1, "R8 napot low end");
        look(2'd1, 2'd3, 32'h1000_00AB, 0, 1'b1, 2'd2, 6'd1, "R8 napot inside");
        look(2'd1, 2'd3, 32'h1000_0100, 0, 1'b0, 2'd0, 6'd0, "R8 napot outside");
        prog(2, mk(4'd2, 6'd1, 1'b0, 1'b0, P_ALL, A_LOAD), 32'h8000_0000);
        look(2'd1, 2'd3, 32'h8000_0000, 0, 1'b1, 2'd2, 6'd1, "R9 ge equal");
        look(2'd1, 2'd3, 32'hFFFF_FFFF, 0, 1'b1, 2'd2, 6'd1, "R9 ge unsigned top");
        look(2'd1, 2'd3, 32'h7FFF_FFFF, 0, 1'b0, 2'd0, 6'd0, "R9 ge below");
        prog(2, mk(4'd3, 6'd1, 1'b0, 1'b0, P_ALL, A_LOAD), 32'h8000_0000);
        look(2'd1, 2'd3, 32'h7FFF_FFFF, 0, 1'b1, 2'd2, 6'd1, "R9 lt below");
        look(2'd1, 2'd3, 32'h8000_0000, 0, 1'b0, 2'd0, 6'd0, "R9 lt equal");
        prog(2, mk(4'd4, 6'd1, 1'b0, 1'b0, P_ALL, A_LOAD), 32'h00FF_1234);
        look(2'd1, 2'd3, 32'hABCD_EF34, 0, 1'b1, 2'd2, 6'd1, "R10 mask low hit");
        look(2'd1, 2'd3, 32'h0000_0035, 0, 1'b0, 2'd0, 6'd0, "R10 mask low miss");
        look(2'd1, 2'd3, 32'h0034_0000, 0, 1'b0, 2'd0, 6'd0, "R10 mask low wrong half");
        prog(2, mk(4'd5, 6'd1, 1'b0, 1'b0, P_ALL, A_LOAD), 32'h00FF_1234);
        look(2'd1, 2'd3, 32'h0034_0000, 0, 1'b1, 2'd2, 6'd1, "R10 mask high hit");
        look(2'd1, 2'd3, 32'h0000_0034, 0, 1'b0, 2'd0, 6'd0, "R10 mask high wrong half");
        prog(2, mk(4'd6, 6'd1, 1'b0, 1'b0, P_ALL, A_LOAD), 32'd0);
        look(2'd1, 2'd3, 32'd0, 0, 1'b0, 2'd0, 6'd0, "R11 mode 6");
        prog(2, mk(4'd15, 6'd1, 1'b0, 1'b0, P_ALL, A_LOAD), 32'd0);
        look(2'd1, 2'd3, 32'd0, 0, 1'b0, 2'd0, 6'd0, "R11 mode 15");
        clear_all();
    endtask

    task automatic t_chain();
        prog(0, mk(4'd0, 6'd1, 1'b1, 1'b0, P_ALL, A_LOAD), 32'h40);
        prog(1, mk(4'd0, 6'd0, 1'b0, 1'b1, P_ALL, A_LOAD), 32'h55);
        look(2'd1, 2'd3, 32'h40, 32'h55, 1'b1, 2'd1, 6'd0, "R12 full chain");
        look(2'd1, 2'd3, 32'h40, 32'h00, 1'b0, 2'd0, 6'd0, "R12 head alone");
        look(2'd1, 2'd3, 32'h00, 32'h55, 1'b0, 2'd0, 6'd0, "R12 broken head");
        prog(3, mk(4'd0, 6'd1, 1'b1, 1'b0, P_ALL, A_LOAD), 32'h77);
        look(2'd1, 2'd3, 32'h77, 32'h00, 1'b0, 2'd0, 6'd0, "R12 unterminated chain");
        clear_all();
    endtask

    task automatic t_priority();
        prog(2, mk(4'd0, 6'd1, 1'b0, 1'b0, P_ALL, A_FETCH), 32'h200);
        prog(3, mk(4'd0, 6'd0, 1'b0, 1'b0, P_ALL, A_FETCH), 32'h200);
        look(2'd0, 2'd3, 32'h200, 0, 1'b1, 2'd2, 6'd1, "R13 lowest wins");
        dbg_cause = 3'd3;
        look(2'd0, 2'd3, 32'h200, 0, 1'b0, 2'd0, 6'd0, "R14 suppressed in debug");
        dbg_cause = 3'd0;
        look(2'd0, 2'd3, 32'h200, 0, 1'b1, 2'd2, 6'd1, "R14 resumes");
        prog(2, 32'd0, 32'd0);
        look(2'd0, 2'd3, 32'h200, 0, 1'b1, 2'd3, 6'd0, "R13 next index and action");
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_regs();
        t_qualify();
        t_unused();
        t_modes();
        t_chain();
        t_priority();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule